// File: doc/BRIEF.md
# Run-time programmable transposed FIR filter

This block is a signed finite impulse response filter built in transposed form. A single data input does two jobs. Each cycle, a select input decides whether the word on that input is a new filter coefficient or a new sample. Coefficients enter serially at the top of a coefficient shift chain. Samples are captured into one sample register, and that register feeds every tap multiplier at once.

Each tap owns a multiplier with a configurable number of pipeline registers. The products are sign-extended into an accumulator chain. In that chain, each register adds its own product to the register of the tap above it. The critical path is therefore one multiply followed by one add, whatever the tap count.

The filter output is the upper slice of the lowest accumulator register, truncated. A host loads the coefficients in impulse-response order and then streams samples, one per cycle.

Top module: `fir_transposed_prog`

## Requirements
- R1: On a clock edge with `load_sample` low, `din` is written to coefficient slot TAPS-1, every slot k below it takes the old value of slot k+1, and the sample register keeps its value. After TAPS such loads, the first word loaded sits in slot 0.
- R2: On a clock edge with `load_sample` high, the sample register takes `din` (two's complement) and all coefficient slots keep their values.
- R3: Let x(e) and c_i(e) be the sample register and coefficient slot i after edge e. After edge m, the full accumulator equals the sum over i of c_i(j)·x(j), where j = m-1-MUL_STAGES-i. In other words, a captured sample reaches slot 0's term MUL_STAGES+1 edges later, and slot i applies to the sample captured i edges before that. An impulse therefore plays back the coefficients in load order.
- R4: Products keep their full 2·DATA_W bits. The accumulator is 2·DATA_W + log2(TAPS) − 1 bits wide (19 bits at the defaults), and sums beyond that width wrap modulo 2^ACC_W with no saturation.
- R5: `dout` is the top OUT_W bits of the slot-0 accumulator. The lower bits are discarded, which rounds toward minus infinity: a full sum of −1 gives all ones on `dout`.
- R6: While `rst_n` is low, the sample register, the multiplier pipelines and the accumulators are zero, so `dout` is 0. Coefficient slots are not reset and keep their values across a reset.
- R7: The top accumulator register takes only its own sign-extended product each edge. Every lower register takes its own product plus the previous value of the register one slot higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the datapath (not the coefficients) |
| load_sample | input | 1 | High: `din` is a sample; low: `din` is a coefficient shifted in |
| din | input | DATA_W | Shared signed sample / coefficient word |
| dout | output | OUT_W | Truncated top slice of the filter sum |

## Verification
The bench plays an impulse through a loaded coefficient set. A slot-order or latency error would replay the coefficients reversed or shifted by a cycle. It drives the most negative value into every coefficient and sample, so a design that widened or saturated the accumulator would not show the expected wrap to −1024. A sum of −1 separates truncation from rounding, since rounding would yield 0. Coefficients are reloaded while a nonzero sample is held, and the filter is reset without reloading; a chain that disturbed the sample during loading, or cleared the coefficients on reset, would break the following outputs.

// File: rtl/fir_tx_pkg.sv
package fir_tx_pkg;

   // Accumulator width for a signed sum of products over a number of taps
   function automatic int acc_width(input int data_w, input int taps);
      return 2 * data_w + $clog2(taps) - 1;
   endfunction

endpackage

// File: rtl/fir_coef_chain.sv
module fir_coef_chain #(
   parameter int DATA_W = 9,
   parameter int TAPS   = 4
) (
   input  logic                          clk,
   input  logic                          shift_en,
   input  logic [DATA_W-1:0]             coef_in,
   output logic [TAPS-1:0][DATA_W-1:0]   coef_q
);

   // Coefficient store: no reset, shifted downward from the top slot
   for (genvar t = 0; t < TAPS; t++) begin : g_slot
      logic [DATA_W-1:0] nxt;
      if (t == TAPS - 1) begin : g_top
         assign nxt = coef_in;
      end else begin : g_low
         assign nxt = coef_q[t+1];
      end
      always_ff @(posedge clk) begin
         if (shift_en) begin
            coef_q[t] <= nxt;
         end
      end
   end

endmodule

// File: rtl/fir_pipe_mult.sv
module fir_pipe_mult #(
   parameter int DATA_W = 9,
   parameter int STAGES = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DATA_W-1:0]      a,
   input  logic [DATA_W-1:0]      b,
   output logic [2*DATA_W-1:0]    p
);

   localparam int PW = 2 * DATA_W;

   logic signed [PW-1:0] prod_c;
   assign prod_c = $signed(a) * $signed(b);

   if (STAGES == 0) begin : g_comb
      assign p = prod_c;
   end else begin : g_piped
      logic [STAGES-1:0][PW-1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st <= '0;
         end else begin
            st[0] <= prod_c;
            for (int k = 1; k < STAGES; k++) begin
               st[k] <= st[k-1];
            end
         end
      end
      assign p = st[STAGES-1];
   end

endmodule

// File: rtl/fir_tx_adder_chain.sv
module fir_tx_adder_chain #(
   parameter int PROD_W = 18,
   parameter int ACC_W  = 19,
   parameter int TAPS   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [TAPS-1:0][PROD_W-1:0]   prod,
   output logic [TAPS-1:0][ACC_W-1:0]    acc
);

   logic [TAPS-1:0][ACC_W-1:0] ext;

   for (genvar t = 0; t < TAPS; t++) begin : g_ext
      assign ext[t] = ACC_W'($signed(prod[t]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else begin
         acc[TAPS-1] <= ext[TAPS-1];
         for (int t = 0; t < TAPS - 1; t++) begin
            acc[t] <= ext[t] + acc[t+1];
         end
      end
   end

endmodule

// File: rtl/fir_transposed_prog.sv
module fir_transposed_prog #(
   parameter int DATA_W     = 9,
   parameter int TAPS       = 4,
   parameter int MUL_STAGES = 3,
   parameter int OUT_W      = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_sample,
   input  logic [DATA_W-1:0]   din,
   output logic [OUT_W-1:0]    dout
);

   localparam int PROD_W = 2 * DATA_W;
   localparam int ACC_W  = fir_tx_pkg::acc_width(DATA_W, TAPS);

   // Elaboration-time parameter checks
   if (TAPS < 2) begin : g_bad_taps
      $error("fir_transposed_prog: TAPS must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("fir_transposed_prog: DATA_W must be at least 2");
   end
   if (MUL_STAGES < 0) begin : g_bad_stages
      $error("fir_transposed_prog: MUL_STAGES must not be negative");
   end
   if (OUT_W < 1 || OUT_W > ACC_W) begin : g_bad_out
      $error("fir_transposed_prog: OUT_W must lie in 1..ACC_W");
   end

   logic [DATA_W-1:0]             x_q;
   logic [TAPS-1:0][DATA_W-1:0]   coef_q;
   logic [TAPS-1:0][PROD_W-1:0]   prod;
   logic [TAPS-1:0][ACC_W-1:0]    acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
      end else if (load_sample) begin
         x_q <= din;
      end
   end

   fir_coef_chain #(
      .DATA_W (DATA_W),
      .TAPS   (TAPS)
   ) u_coef (
      .clk      (clk),
      .shift_en (!load_sample),
      .coef_in  (din),
      .coef_q   (coef_q)
   );

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      fir_pipe_mult #(
         .DATA_W (DATA_W),
         .STAGES (MUL_STAGES)
      ) u_mul (
         .clk   (clk),
         .rst_n (rst_n),
         .a     (x_q),
         .b     (coef_q[t]),
         .p     (prod[t])
      );
   end

   fir_tx_adder_chain #(
      .PROD_W (PROD_W),
      .ACC_W  (ACC_W),
      .TAPS   (TAPS)
   ) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .prod  (prod),
      .acc   (acc)
   );

   assign dout = acc[0][ACC_W-1 -: OUT_W];

endmodule

// File: rtl/fir_transposed_prog_chk.sv
module fir_transposed_prog_chk #(
   parameter int DATA_W = 9,
   parameter int TAPS   = 4,
   parameter int PROD_W = 18,
   parameter int ACC_W  = 19
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          load_sample,
   input logic [DATA_W-1:0]             din,
   input logic [DATA_W-1:0]             x_q,
   input logic [TAPS-1:0][DATA_W-1:0]   coef_q,
   input logic [TAPS-1:0][PROD_W-1:0]   prod,
   input logic [TAPS-1:0][ACC_W-1:0]    acc
);

   AST_COEF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      !load_sample |=> coef_q[TAPS-1] == $past(din)); // R1

   AST_COEF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !load_sample |=> coef_q[TAPS-2:0] == $past(coef_q[TAPS-1:1])); // R1

   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_sample |=> $stable(x_q)); // R1

   AST_SAMPLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      load_sample |=> x_q == $past(din)); // R2

   AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      load_sample |=> $stable(coef_q)); // R2

   AST_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> acc[TAPS-1] == ACC_W'($signed($past(prod[TAPS-1])))); // R7

   for (genvar t = 0; t < TAPS - 1; t++) begin : g_link
      AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> acc[t] == ACC_W'($signed($past(prod[t]))) + $past(acc[t+1])); // R7
   end

endmodule

bind fir_transposed_prog fir_transposed_prog_chk #(
   .DATA_W (DATA_W),
   .TAPS   (TAPS),
   .PROD_W (PROD_W),
   .ACC_W  (ACC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_sample (load_sample),
   .din         (din),
   .x_q         (x_q),
   .coef_q      (coef_q),
   .prod        (prod),
   .acc         (acc)
);

// File: tb/fir_transposed_prog_tb_top.sv
`timescale 1ns/1ps
module fir_transposed_prog_tb_top;

   localparam int DATA_W = 9;
   localparam int TAPS   = 4;
   localparam int STG    = 3;
   localparam int OUT_W  = 11;
   localparam int ACC_W  = 2 * DATA_W + $clog2(TAPS) - 1;
   localparam int HIST   = 1024;
   localparam int NV     = 20;

   // Each entry: {load_sample, din}
   localparam logic [DATA_W:0] VEC [NV] = '{
      {1'b0, 9'h064}, {1'b0, 9'h1CE}, {1'b0, 9'h0C8}, {1'b0, 9'h100},
      {1'b1, 9'h0FF}, {1'b1, 9'h000}, {1'b1, 9'h000}, {1'b1, 9'h000},
      {1'b1, 9'h000}, {1'b1, 9'h000}, {1'b1, 9'h000}, {1'b1, 9'h000},
      {1'b1, 9'h07F}, {1'b1, 9'h181}, {1'b1, 9'h0AA}, {1'b1, 9'h155},
      {1'b1, 9'h001}, {1'b1, 9'h1FF}, {1'b1, 9'h100}, {1'b1, 9'h0FF}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_sample = 1'b1;
   logic [DATA_W-1:0] din = '0;
   logic [OUT_W-1:0]  dout;

   int n_chk = 0;
   int n_err = 0;
   int edge_n = 0;
   bit arm = 1'b0;
   int xm = 0;
   int cm [TAPS];
   int xh [HIST];
   int ch [HIST][TAPS];

   always #2 clk = ~clk;

   fir_transposed_prog #(
      .DATA_W     (DATA_W),
      .TAPS       (TAPS),
      .MUL_STAGES (STG),
      .OUT_W      (OUT_W)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_sample (load_sample),
      .din         (din),
      .dout        (dout)
   );

   function automatic logic [OUT_W-1:0] expect_out(input int m);
      longint s;
      logic [ACC_W-1:0] a;
      s = 0;
      for (int i = 0; i < TAPS; i++) begin
         int j;
         j = m - 1 - STG - i;
         if (j >= 0) s += longint'(ch[j][i]) * longint'(xh[j]);
      end
      a = s[ACC_W-1:0];
      return a[ACC_W-1 -: OUT_W];
   endfunction

   task automatic check(input string tag, input logic [OUT_W-1:0] act,
                        input logic [OUT_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: dout=%0d expected %0d", tag, $signed(act), $signed(exp));
      end
   endtask

   task automatic step(input logic ld, input logic [DATA_W-1:0] d, input string tag);
      @(negedge clk);
      load_sample = ld;
      din = d;
      @(posedge clk);
      #1;
      if (!ld) begin
         for (int i = 0; i < TAPS - 1; i++) cm[i] = cm[i+1];
         cm[TAPS-1] = int'($signed(d));
      end
      if (!rst_n) xm = 0;
      else if (ld) xm = int'($signed(d));
      xh[edge_n] = xm;
      for (int i = 0; i < TAPS; i++) ch[edge_n][i] = cm[i];
      if (arm) check(tag, dout, expect_out(edge_n));
      edge_n++;
   endtask

   initial begin
      for (int i = 0; i < TAPS; i++) cm[i] = 0;
      // Reset state
      for (int k = 0; k < 4; k++) step(1'b1, '0, "R6");
      check("R6", dout, '0);
      rst_n = 1'b1;
      arm = 1'b1;

      // Vector table: coefficient load, impulse, then assorted samples
      for (int v = 0; v < NV; v++) begin
         step(VEC[v][DATA_W], VEC[v][DATA_W-1:0], (v < TAPS) ? "R1" : "R3");
      end
      for (int k = 0; k < 8; k++) step(1'b1, '0, "R3");

      // Random stream through the accumulator chain
      for (int k = 0; k < 40; k++) step(1'b1, DATA_W'($urandom), "R7");

      // Truncation: coefficients 1,0,0,0 and a sample of -1
      step(1'b0, 9'h001, "R1");
      for (int k = 0; k < TAPS - 1; k++) step(1'b0, '0, "R1");
      step(1'b1, 9'h1FF, "R5");
      for (int k = 0; k < 8; k++) step(1'b1, '0, "R5");

      // Wrap: every coefficient and sample at the most negative value
      for (int k = 0; k < TAPS; k++) step(1'b0, 9'h100, "R1");
      for (int k = 0; k < 10; k++) step(1'b1, 9'h100, "R4");

      // Reload coefficients while the held sample is nonzero
      step(1'b1, 9'h05A, "R2");
      step(1'b0, 9'h010, "R2");
      step(1'b0, 9'h1F0, "R2");
      step(1'b0, 9'h07F, "R2");
      step(1'b0, 9'h183, "R2");
      for (int k = 0; k < 12; k++) step(1'b1, DATA_W'($urandom), "R2");

      // Reset without reloading coefficients
      @(negedge clk);
      rst_n = 1'b0;
      arm = 1'b0;
      #1;
      check("R6", dout, '0);
      for (int k = 0; k < 10; k++) step(1'b1, DATA_W'($urandom), "R6");
      check("R6", dout, '0);
      rst_n = 1'b1;
      arm = 1'b1;
      step(1'b1, 9'h0C0, "R6");
      for (int k = 0; k < 8; k++) step(1'b1, '0, "R6");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule